// File: doc/BRIEF.md
# Serial Receive Control and Status Register

This block is the control and status register of a serial receiver that runs either asynchronously or as a synchronous master or slave. Software writes the port enable, the 8-bit or 9-bit frame select, a single-shot receive enable and a continuous receive enable. The block reads these together with the receive mode and decides whether the receiver is armed. A bit-level receiver core, outside this block, sends one pulse per completed frame with the frame's data and framing status. Frames accepted while armed go into a two-entry receive buffer.

A strobe on the data read input pops the oldest buffered frame. The popped byte is presented as the received data. In the same cycle the framing error flag and the ninth data bit are refreshed from the popped entry, so those two status bits always describe the frame just read. If a frame arrives while both buffer entries are unread, a sticky overrun flag is set. The buffer keeps its contents and reception stays disarmed until software writes the continuous enable to 0.

Top module: `rxcs_top`

## Requirements
- R1: Register layout, most significant bit first: [7] port enable, [6] nine-bit select, [5] single-shot enable, [4] continuous enable, [3] always 0, [2] framing error, [1] overrun, [0] ninth data bit. Bits 7..4 are writable and reset to 0. Bits 3..0 ignore writes. Bits 2 and 1 reset to 0.
- R2: `rx_nine_o` follows bit 6. A frame's bit 8 is kept only when bit 6 is 1 at the time the frame is accepted; otherwise it is stored as 0.
- R3: `rx_armed_o` is 1 only when the port is enabled and the overrun flag is clear, and one more condition holds. In asynchronous mode (`mode_i`=00 or 01) and in synchronous slave mode (11), the continuous enable must be 1. In synchronous master mode (10), the continuous enable or the single-shot enable must be 1.
- R4: In synchronous master mode, a frame accepted while the continuous enable is 0 clears the single-shot enable. While the continuous enable is 1, the single-shot enable is left unchanged.
- R5: With the port enable at 0, the receiver is disarmed and frame pulses change nothing.
- R6: A frame pulse while disarmed is ignored.
- R7: Up to two accepted frames are buffered and read back in arrival order. `rx_avail_o` is 1 while at least one frame is unread.
- R8: A frame accepted while both entries are unread sets the overrun flag and is dropped. The buffered frames are kept, and later frames are blocked.
- R9: The overrun flag is cleared only by a register write with bit 4 at 0. Data reads and writes with bit 4 at 1 leave it set.
- R10: A data read with the buffer non-empty updates `rx_byte_o`, the framing error flag and the ninth data bit from the oldest entry, one cycle after the strobe. A data read with the buffer empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| mode_i | input | 2 | 00/01 asynchronous, 10 synchronous master, 11 synchronous slave |
| frame_done_i | input | 1 | One-cycle pulse per completed frame |
| frame_data_i | input | 9 | Received frame bits, bit 8 is the ninth bit |
| frame_ferr_i | input | 1 | Framing error of the completed frame |
| data_rd_i | input | 1 | Data register read strobe |
| rx_byte_o | output | 8 | Byte of the most recently read frame |
| rx_avail_o | output | 1 | At least one frame unread |
| rx_armed_o | output | 1 | Reception armed |
| rx_nine_o | output | 1 | Nine-bit frame select |

## Verification
A wrong arming decision shows on `rx_armed_o` in the cycle after the register write or the frame that caused it. It also shows as a missing or extra `rx_avail_o` one cycle after a frame pulse. A buffer pointer or count fault appears as bytes returned out of order, or as an early or missing overrun bit in the register read value, one cycle after the offending frame or read. A lost status update appears as a stale framing error or ninth bit in the cycle after a data read.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
    typedef enum logic [1:0] {
        MODE_ASYNC   = 2'b00,
        MODE_ASYNC_B = 2'b01,
        MODE_MASTER  = 2'b10,
        MODE_SLAVE   = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic       ferr;
        logic [8:0] bits;
    } rx_entry_t;

    typedef struct packed {
        logic port_en;
        logic nine;
        logic one_shot;
        logic cont;
    } ctrl_st_t;
endpackage

// File: rtl/rxcs_ctrl.sv
module rxcs_ctrl
    import rxcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [3:0] wbits_i,
    input  logic [1:0] mode_i,
    input  logic       accept_i,
    input  logic       ovr_i,
    output ctrl_st_t   st_o,
    output logic       armed_o
);
    ctrl_st_t st_d, st_q;
    logic     is_master;

    assign is_master = (mode_i == MODE_MASTER);

    always_comb begin
        st_d = st_q;
        if (accept_i && is_master && !st_q.cont)
            st_d.one_shot = 1'b0;
        if (wr_i) begin
            st_d.port_en  = wbits_i[3];
            st_d.nine     = wbits_i[2];
            st_d.one_shot = wbits_i[1];
            st_d.cont     = wbits_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.port_en && !ovr_i &&
                     (st_q.cont || (is_master && st_q.one_shot));
    assign st_o    = st_q;

    AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && is_master && !st_q.cont && !wr_i) |=> !st_q.one_shot); // R4
    AST_CONT_KEEPS_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cont && st_q.one_shot && !wr_i) |=> st_q.one_shot); // R4
endmodule

// File: rtl/rxcs_fifo.sv
module rxcs_fifo
    import rxcs_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  logic      pop_i,
    input  rx_entry_t wentry_i,
    output rx_entry_t head_o,
    output logic      full_o,
    output logic      empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t  st_d, st_q;
    rx_entry_t mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = bump(st_q.wp);
        if (pop_i)  st_d.rp = bump(st_q.rp);
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (push_i && st_q.wp == PTR_W'(i))
                mem_q[i] <= wentry_i;
        end
    end

    assign head_o  = mem_q[st_q.rp];
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !pop_i); // R10
endmodule

// File: rtl/rxcs_status.sv
module rxcs_status
    import rxcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept_i,
    input  logic      full_i,
    input  logic      pop_i,
    input  rx_entry_t head_i,
    input  logic      wr_i,
    input  logic      wcont_i,
    output logic      ovr_o,
    output logic      ferr_o,
    output logic      bit9_o,
    output logic [7:0] byte_o
);
    typedef struct packed {
        logic       ovr;
        logic       ferr;
        logic       bit9;
        logic [7:0] rbyte;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic     ovr_set;

    assign ovr_set = accept_i && full_i && !pop_i;

    always_comb begin
        st_d = st_q;
        if (ovr_set)
            st_d.ovr = 1'b1;
        if (wr_i && !wcont_i)
            st_d.ovr = 1'b0;
        if (pop_i) begin
            st_d.ferr  = head_i.ferr;
            st_d.bit9  = head_i.bits[8];
            st_d.rbyte = head_i.bits[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr_o  = st_q.ovr;
    assign ferr_o = st_q.ferr;
    assign bit9_o = st_q.bit9;
    assign byte_o = st_q.rbyte;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !(wr_i && !wcont_i)) |=> st_q.ovr); // R9
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(full_i)); // R8
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(st_q.rbyte) && $stable(st_q.ferr)); // R10
endmodule

// File: rtl/rxcs_top.sv
module rxcs_top
    import rxcs_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic [1:0] mode_i,
    input  logic       frame_done_i,
    input  logic [8:0] frame_data_i,
    input  logic       frame_ferr_i,
    input  logic       data_rd_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_avail_o,
    output logic       rx_armed_o,
    output logic       rx_nine_o
);
    ctrl_st_t  ctl;
    rx_entry_t wentry, head;
    logic      armed, accept, push, pop, full, empty, ovr, ferr, bit9;

    assign accept = frame_done_i && armed;
    assign pop    = data_rd_i && !empty;
    assign push   = accept && (!full || pop);

    always_comb begin
        wentry.ferr = frame_ferr_i;
        wentry.bits = {frame_data_i[8] & ctl.nine, frame_data_i[7:0]};
    end

    rxcs_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .wbits_i (reg_wdata_i[7:4]),
        .mode_i  (mode_i),
        .accept_i(accept),
        .ovr_i   (ovr),
        .st_o    (ctl),
        .armed_o (armed)
    );

    rxcs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wentry_i(wentry),
        .head_o  (head),
        .full_o  (full),
        .empty_o (empty)
    );

    rxcs_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .full_i  (full),
        .pop_i   (pop),
        .head_i  (head),
        .wr_i    (reg_wr_i),
        .wcont_i (reg_wdata_i[4]),
        .ovr_o   (ovr),
        .ferr_o  (ferr),
        .bit9_o  (bit9),
        .byte_o  (rx_byte_o)
    );

    assign reg_rdata_o = {ctl.port_en, ctl.nine, ctl.one_shot, ctl.cont,
                          1'b0, ferr, ovr, bit9};
    assign rx_avail_o  = !empty;
    assign rx_armed_o  = armed;
    assign rx_nine_o   = ctl.nine;

    AST_DISABLED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.port_en && frame_done_i && !pop) |=> $stable(rx_avail_o)); // R5
    AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !push); // R8
    AST_NINE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ctl.nine) |-> !wentry.bits[8]); // R2
endmodule

// File: tb/sim_rxcs_top.sv
module sim_rxcs_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] mode = 2'b00;
    logic       frame_done = 1'b0;
    logic [8:0] frame_data = '0;
    logic       frame_ferr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_avail, rx_armed, rx_nine;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rxcs_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .mode_i(mode), .frame_done_i(frame_done),
        .frame_data_i(frame_data), .frame_ferr_i(frame_ferr), .data_rd_i(data_rd),
        .rx_byte_o(rx_byte), .rx_avail_o(rx_avail), .rx_armed_o(rx_armed),
        .rx_nine_o(rx_nine)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic send(input logic [8:0] d, input logic fe);
        @(negedge clk); frame_done = 1'b1; frame_data = d; frame_ferr = fe;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic rd_data();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) rd_data();
    endtask

    task automatic t_reset();
        chk("R1 reset reg", {1'b0, reg_rdata & 8'hFE}, 9'h000);
        chk("R1 reset armed", {8'h0, rx_armed}, 9'h0);
        chk("R7 reset avail", {8'h0, rx_avail}, 9'h0);
    endtask

    task automatic t_regs();
        wr_reg(8'hFF);
        chk("R1 write ff", {1'b0, reg_rdata & 8'hFE}, 9'h0F0);
        chk("R2 nine out", {8'h0, rx_nine}, 9'h1);
        wr_reg(8'h00);
        chk("R2 nine off", {8'h0, rx_nine}, 9'h0);
    endtask

    task automatic t_port_off();
        mode = 2'b00;
        wr_reg(8'h10);
        chk("R5 disarmed", {8'h0, rx_armed}, 9'h0);
        send(9'h05A, 1'b0);
        chk("R5 frame ignored", {8'h0, rx_avail}, 9'h0);
    endtask

    task automatic t_async_arm();
        mode = 2'b00;
        wr_reg(8'hA0);
        chk("R3 async one-shot ignored", {8'h0, rx_armed}, 9'h0);
        send(9'h033, 1'b0);
        chk("R6 unarmed frame ignored", {8'h0, rx_avail}, 9'h0);
        mode = 2'b01;
        wr_reg(8'h90);
        chk("R3 async cont arms", {8'h0, rx_armed}, 9'h1);
    endtask

    task automatic t_fifo();
        mode = 2'b00;
        wr_reg(8'h90);
        send(9'h155, 1'b1);
        chk("R7 avail after frame", {8'h0, rx_avail}, 9'h1);
        send(9'h0AA, 1'b0);
        rd_data();
        chk("R10 first byte", {1'b0, rx_byte}, 9'h055);
        chk("R10 ferr of first", {8'h0, reg_rdata[2]}, 9'h1);
        chk("R2 bit9 masked in 8-bit", {8'h0, reg_rdata[0]}, 9'h0);
        chk("R7 still avail", {8'h0, rx_avail}, 9'h1);
        rd_data();
        chk("R7 second byte in order", {1'b0, rx_byte}, 9'h0AA);
        chk("R10 ferr of second", {8'h0, reg_rdata[2]}, 9'h0);
        chk("R7 empty", {8'h0, rx_avail}, 9'h0);
        rd_data();
        chk("R10 empty read keeps byte", {1'b0, rx_byte}, 9'h0AA);
    endtask

    task automatic t_nine();
        wr_reg(8'hD0);
        send(9'h1C3, 1'b0);
        rd_data();
        chk("R2 nine-bit byte", {1'b0, rx_byte}, 9'h0C3);
        chk("R2 ninth bit kept", {8'h0, reg_rdata[0]}, 9'h1);
    endtask

    task automatic t_overrun();
        mode = 2'b00;
        wr_reg(8'h90);
        send(9'h011, 1'b0);
        send(9'h022, 1'b0);
        chk("R8 no overrun at two", {8'h0, reg_rdata[1]}, 9'h0);
        send(9'h033, 1'b0);
        chk("R8 overrun set", {8'h0, reg_rdata[1]}, 9'h1);
        chk("R8 disarmed on overrun", {8'h0, rx_armed}, 9'h0);
        send(9'h044, 1'b0);
        rd_data();
        chk("R8 kept first", {1'b0, rx_byte}, 9'h011);
        rd_data();
        chk("R8 kept second", {1'b0, rx_byte}, 9'h022);
        chk("R8 later frames blocked", {8'h0, rx_avail}, 9'h0);
        chk("R9 read does not clear", {8'h0, reg_rdata[1]}, 9'h1);
        wr_reg(8'h90);
        chk("R9 cont=1 write keeps", {8'h0, reg_rdata[1]}, 9'h1);
        wr_reg(8'h80);
        chk("R9 cont=0 write clears", {8'h0, reg_rdata[1]}, 9'h0);
        wr_reg(8'h90);
        chk("R3 rearmed", {8'h0, rx_armed}, 9'h1);
    endtask

    task automatic t_master();
        mode = 2'b10;
        wr_reg(8'hA0);
        chk("R3 master one-shot arms", {8'h0, rx_armed}, 9'h1);
        send(9'h066, 1'b0);
        chk("R4 one-shot self clears", {8'h0, reg_rdata[5]}, 9'h0);
        chk("R4 disarmed after byte", {8'h0, rx_armed}, 9'h0);
        send(9'h077, 1'b0);
        rd_data();
        chk("R6 only one byte", {8'h0, rx_avail}, 9'h0);
        wr_reg(8'hB0);
        send(9'h088, 1'b0);
        chk("R4 cont keeps one-shot", {8'h0, reg_rdata[5]}, 9'h1);
        drain();
    endtask

    task automatic t_slave();
        mode = 2'b11;
        wr_reg(8'hA0);
        chk("R3 slave ignores one-shot", {8'h0, rx_armed}, 9'h0);
        send(9'h099, 1'b0);
        chk("R6 slave frame ignored", {8'h0, rx_avail}, 9'h0);
        wr_reg(8'h90);
        chk("R3 slave cont arms", {8'h0, rx_armed}, 9'h1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_regs();
                t_port_off();
                t_async_arm();
                t_fifo();
                t_nine();
                t_overrun();
                t_master();
                t_slave();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule